// File: doc/BRIEF.md
# Burst-Mode Stereo Serial Transmitter

This block turns one parallel stereo sample per output slot into two serial lines that run side by side. The left line and the right line carry two's-complement words, most significant bit first. A gated bit clock pulses only while word bits are on the lines. A word clock marks the two halves of each slot. An active-low settle strobe flags the quiet stretch that follows the last bit. A one-cycle slot strobe starts the slot timing. After that the block free-runs from slot to slot until the next strobe restarts it.

The clock `clk` runs at twice the system clock, so each half of a bit-clock period is a whole number of `clk` cycles. There are two clock ratios. At the 384x ratio a slot holds 24 bit periods of four `clk` cycles each. At the 256x ratio a slot holds 32 bit periods of two `clk` cycles each. The word length can be 24, 22, 20 or 18 bits, and the block always sends the upper bits of the 24-bit sample.

Samples come in on a valid/ready port backed by a one-entry holding register. `s_ready` is high whenever that register is empty. A sample transfers on a clock edge where `s_valid` and `s_ready` are both high. The producer must keep the sample stable until that edge. The held sample is consumed at the next slot start, and `s_ready` rises again in the following cycle. A slot that starts with no held sample sends zeros. The ratio and word-length pins are sampled only at slot start.

Top module: `burst_serial_tx`

## Requirements
- R1: While `rst_n` is low, and after release until the first `slot_strobe`, `ser_l`, `ser_r`, `bit_clk` and `word_clk` are low, `settle_n` is high, and `s_ready` is high.
- R2: `ratio_256` = 0 selects the 384x ratio, where a slot lasts 96 `clk` cycles (24 bit periods of 4 cycles). `ratio_256` = 1 selects the 256x ratio, where a slot lasts 64 cycles (32 bit periods of 2 cycles). Slots repeat without a strobe, and a strobe restarts a slot at position 0 on the next cycle's outputs.
- R3: `wl_sel` gives the word length: 2'b00 = 24, 2'b01 = 22, 2'b10 = 20, 2'b11 = 18 bits. `bit_clk` pulses exactly that many times per slot, and it is high during the second half of each data bit period.
- R4: During data bit k (k = 0 first), `ser_l` and `ser_r` carry bit 23-k of the left and right 24-bit samples. They change only at bit-period boundaries (the falling edge of `bit_clk`) and are low outside the data bits.
- R5: The first data bit sits in bit period 0 at the 256x ratio for every word length. At the 384x ratio it sits in period 1 for 18, 20 and 22 bits and in period 0 for 24 bits.
- R6: `word_clk` is high for the first half of the slot's bit periods and low for the second half, so its rising edge marks slot position 0.
- R7: `settle_n` is low from the bit period after the last data bit to the end of the slot, and high otherwise. It never goes low in 24-bit words at the 384x ratio.
- R8: `s_ready` is low exactly while a sample is held. A held sample goes out in the next slot, and a slot that starts with nothing held sends all zeros.
- R9: A change on `ratio_256` or `wl_sel` in the middle of a slot does not alter that slot. It applies from the next slot start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the system clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_strobe | input | 1 | One-cycle pulse that starts a slot |
| ratio_256 | input | 1 | 1 = 256x slot layout, 0 = 384x |
| wl_sel | input | 2 | Output word length select |
| s_valid | input | 1 | Sample offered |
| s_ready | output | 1 | Holding register empty |
| s_left | input | 24 | Left sample, two's complement |
| s_right | input | 24 | Right sample, two's complement |
| ser_l | output | 1 | Left serial data |
| ser_r | output | 1 | Right serial data |
| bit_clk | output | 1 | Gated bit clock |
| word_clk | output | 1 | Slot half marker |
| settle_n | output | 1 | Low during the quiet tail of a slot |

## Verification
A wrong slot position shows up within one slot as a word clock rise at the wrong cycle or a wrong count of bit-clock pulses. A wrong latched configuration changes the start bit or the settle window from the next slot on. A wrong holding-register state shows up on `s_ready` in the next cycle, and as a wrong or repeated word one slot later. The bench runs a behavioural model and compares every output on every cycle, so any of these faults is reported in the cycle where it first reaches a port.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

  localparam int NB_W = 5;

  typedef enum logic [1:0] {
    WL_24 = 2'b00,
    WL_22 = 2'b01,
    WL_20 = 2'b10,
    WL_18 = 2'b11
  } wlen_e;

  typedef struct packed {
    logic            r384;
    logic [NB_W-1:0] nbits;
  } slot_cfg_t;

  function automatic logic [NB_W-1:0] wl_to_bits(input logic [1:0] sel);
    case (wlen_e'(sel))
      WL_24:   return NB_W'(24);
      WL_22:   return NB_W'(22);
      WL_20:   return NB_W'(20);
      default: return NB_W'(18);
    endcase
  endfunction

endpackage

// File: rtl/sbt_slot_timer.sv
module sbt_slot_timer #(
  parameter int BITS_HI = 24,
  parameter int BITS_LO = 32,
  parameter int CPB_HI  = 4,
  parameter int CPB_LO  = 2,
  localparam int SUB_W  = $clog2((CPB_HI > CPB_LO) ? CPB_HI : CPB_LO),
  localparam int BIT_W  = $clog2((BITS_HI > BITS_LO) ? BITS_HI : BITS_LO)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic             r384,
  output logic             emit,
  output logic             slot_begin,
  output logic [SUB_W-1:0] cur_sub,
  output logic [BIT_W-1:0] cur_bit
);

  localparam logic [SUB_W-1:0] SUB_LAST_HI = SUB_W'(CPB_HI - 1);
  localparam logic [SUB_W-1:0] SUB_LAST_LO = SUB_W'(CPB_LO - 1);
  localparam logic [BIT_W-1:0] BIT_LAST_HI = BIT_W'(BITS_HI - 1);
  localparam logic [BIT_W-1:0] BIT_LAST_LO = BIT_W'(BITS_LO - 1);

  logic             run_q;
  logic [SUB_W-1:0] sub_q;
  logic [BIT_W-1:0] bit_q;
  logic             sub_last, bit_last;

  assign emit       = strobe | run_q;
  assign cur_sub    = strobe ? '0 : sub_q;
  assign cur_bit    = strobe ? '0 : bit_q;
  assign slot_begin = emit && (cur_sub == '0) && (cur_bit == '0);

  always_comb begin
    sub_last = r384 ? (cur_sub == SUB_LAST_HI) : (cur_sub == SUB_LAST_LO);
    bit_last = r384 ? (cur_bit == BIT_LAST_HI) : (cur_bit == BIT_LAST_LO);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      sub_q <= '0;
      bit_q <= '0;
    end else if (emit) begin
      run_q <= 1'b1;
      if (sub_last) begin
        sub_q <= '0;
        bit_q <= bit_last ? '0 : cur_bit + 1'b1;
      end else begin
        sub_q <= cur_sub + 1'b1;
        bit_q <= cur_bit;
      end
    end
  end

endmodule

// File: rtl/sbt_sample_hold.sv
module sbt_sample_hold #(
  parameter int W     = 24,
  parameter int CHANS = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    s_valid,
  output logic                    s_ready,
  input  logic [CHANS-1:0][W-1:0] chan_in,
  input  logic                    take,
  output logic [CHANS-1:0][W-1:0] word
);

  logic full_q;
  logic accept;

  assign s_ready = !full_q;
  assign accept  = s_valid && !full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      full_q <= 1'b0;
    else if (accept) full_q <= 1'b1;
    else if (take)   full_q <= 1'b0;
  end

  for (genvar ch = 0; ch < CHANS; ch++) begin : g_chan
    logic [W-1:0] hold_q;
    logic [W-1:0] cur_q;

    assign word[ch] = take ? (full_q ? hold_q : '0) : cur_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_q <= '0;
        cur_q  <= '0;
      end else begin
        if (accept) hold_q <= chan_in[ch];
        if (take)   cur_q  <= word[ch];
      end
    end
  end

endmodule

// File: rtl/sbt_bit_shaper.sv
module sbt_bit_shaper
  import sbt_pkg::*;
#(
  parameter int W       = 24,
  parameter int CHANS   = 2,
  parameter int BITS_HI = 24,
  parameter int BITS_LO = 32,
  parameter int CPB_HI  = 4,
  parameter int CPB_LO  = 2,
  parameter int LATE    = 1,
  parameter int SUB_W   = 2,
  parameter int BIT_W   = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    emit,
  input  slot_cfg_t               cfg,
  input  logic [SUB_W-1:0]        cur_sub,
  input  logic [BIT_W-1:0]        cur_bit,
  input  logic [CHANS-1:0][W-1:0] word,
  output logic [CHANS-1:0]        ser,
  output logic                    bit_clk,
  output logic                    word_clk,
  output logic                    settle_n
);

  localparam int AW    = 8;
  localparam int IDX_W = $clog2(W);

  logic [AW-1:0]    p, first, stop, k, half_sub, half_slot;
  logic             in_win, second;
  logic [IDX_W-1:0] idx;
  logic [CHANS-1:0] ser_d;

  always_comb begin
    p         = AW'(cur_bit);
    first     = (cfg.r384 && (cfg.nbits != NB_W'(W))) ? AW'(LATE) : '0;
    stop      = first + AW'(cfg.nbits);
    in_win    = (p >= first) && (p < stop);
    k         = p - first;
    idx       = IDX_W'(W - 1) - IDX_W'(k);
    half_sub  = cfg.r384 ? AW'(CPB_HI / 2) : AW'(CPB_LO / 2);
    half_slot = cfg.r384 ? AW'(BITS_HI / 2) : AW'(BITS_LO / 2);
    second    = AW'(cur_sub) >= half_sub;
  end

  for (genvar ch = 0; ch < CHANS; ch++) begin : g_lane
    assign ser_d[ch] = in_win ? word[ch][idx] : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser      <= '0;
      bit_clk  <= 1'b0;
      word_clk <= 1'b0;
      settle_n <= 1'b1;
    end else if (emit) begin
      ser      <= ser_d;
      bit_clk  <= in_win && second;
      word_clk <= p < half_slot;
      settle_n <= !(p >= stop);
    end
  end

endmodule

// File: rtl/burst_serial_tx.sv
module burst_serial_tx
  import sbt_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int BITS_HI  = 24,
  parameter int BITS_LO  = 32,
  parameter int CPB_HI   = 4,
  parameter int CPB_LO   = 2,
  parameter int LATE     = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                slot_strobe,
  input  logic                ratio_256,
  input  logic [1:0]          wl_sel,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_left,
  input  logic [SAMPLE_W-1:0] s_right,
  output logic                ser_l,
  output logic                ser_r,
  output logic                bit_clk,
  output logic                word_clk,
  output logic                settle_n
);

  localparam int CHANS = 2;
  localparam int SUB_W = $clog2((CPB_HI > CPB_LO) ? CPB_HI : CPB_LO);
  localparam int BIT_W = $clog2((BITS_HI > BITS_LO) ? BITS_HI : BITS_LO);

  logic                           emit, slot_begin;
  logic [SUB_W-1:0]               cur_sub;
  logic [BIT_W-1:0]               cur_bit;
  slot_cfg_t                      cfg_q, cfg_pins, cfg_eff;
  logic [CHANS-1:0][SAMPLE_W-1:0] chan_in, word;
  logic [CHANS-1:0]               ser;

  assign cfg_pins = '{r384: !ratio_256, nbits: wl_to_bits(wl_sel)};
  assign cfg_eff  = slot_begin ? cfg_pins : cfg_q;
  assign chan_in  = {s_right, s_left};
  assign ser_l    = ser[0];
  assign ser_r    = ser[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cfg_q <= '{r384: 1'b1, nbits: NB_W'(SAMPLE_W)};
    else if (slot_begin) cfg_q <= cfg_pins;
  end

  sbt_slot_timer #(
    .BITS_HI(BITS_HI), .BITS_LO(BITS_LO), .CPB_HI(CPB_HI), .CPB_LO(CPB_LO)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .strobe(slot_strobe), .r384(cfg_eff.r384),
    .emit(emit), .slot_begin(slot_begin), .cur_sub(cur_sub), .cur_bit(cur_bit)
  );

  sbt_sample_hold #(.W(SAMPLE_W), .CHANS(CHANS)) u_hold (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .chan_in(chan_in), .take(slot_begin), .word(word)
  );

  sbt_bit_shaper #(
    .W(SAMPLE_W), .CHANS(CHANS), .BITS_HI(BITS_HI), .BITS_LO(BITS_LO),
    .CPB_HI(CPB_HI), .CPB_LO(CPB_LO), .LATE(LATE), .SUB_W(SUB_W), .BIT_W(BIT_W)
  ) u_shape (
    .clk(clk), .rst_n(rst_n), .emit(emit), .cfg(cfg_eff),
    .cur_sub(cur_sub), .cur_bit(cur_bit), .word(word),
    .ser(ser), .bit_clk(bit_clk), .word_clk(word_clk), .settle_n(settle_n)
  );

endmodule

// File: rtl/burst_serial_tx_checker.sv
module burst_serial_tx_checker (
  input logic clk,
  input logic rst_n,
  input logic s_valid,
  input logic s_ready,
  input logic ser_l,
  input logic ser_r,
  input logic bit_clk,
  input logic word_clk,
  input logic settle_n
);

  p_data_held_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_clk |-> ($stable(ser_l) && $stable(ser_r)));

  p_ready_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);

  p_settle_no_clock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !settle_n |-> !bit_clk);

  p_settle_lines_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !settle_n |-> (!ser_l && !ser_r));

  p_slot_open_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_clk) |-> (!bit_clk && settle_n));

endmodule

bind burst_serial_tx burst_serial_tx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .ser_l(ser_l), .ser_r(ser_r), .bit_clk(bit_clk), .word_clk(word_clk),
  .settle_n(settle_n)
);

// File: tb/burst_serial_tx_test.sv
module burst_serial_tx_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slot_strobe = 1'b0;
  logic        ratio_256 = 1'b1;
  logic [1:0]  wl_sel = 2'b00;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [23:0] s_left = '0, s_right = '0;
  logic        ser_l, ser_r, bit_clk, word_clk, settle_n;

  int    compared = 0, mismatched = 0;
  bit    cmp_en = 0, feed_en = 0, done = 0, acc = 0;
  string phase = "R1";
  int    seq = 0;

  // behavioural model state
  int          m_run = 0, m_sub = 0, m_bit = 0, m_n = 24;
  bit          m_r384 = 1, m_full = 0;
  logic [23:0] m_hl = '0, m_hr = '0, m_wl = '0, m_wr = '0;
  logic        e_l = 0, e_r = 0, e_b = 0, e_w = 0, e_s = 1, e_rdy = 1;

  burst_serial_tx uut (
    .clk(clk), .rst_n(rst_n), .slot_strobe(slot_strobe), .ratio_256(ratio_256),
    .wl_sel(wl_sel), .s_valid(s_valid), .s_ready(s_ready), .s_left(s_left),
    .s_right(s_right), .ser_l(ser_l), .ser_r(ser_r), .bit_clk(bit_clk),
    .word_clk(word_clk), .settle_n(settle_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    int cs, cb, cpb, sb, first, stop;
    bit emit_now, rdy_old;
    acc = 0;
    if (!rst_n) begin
      m_run = 0; m_sub = 0; m_bit = 0; m_full = 0; m_r384 = 1; m_n = 24;
      m_wl = '0; m_wr = '0;
      e_l = 0; e_r = 0; e_b = 0; e_w = 0; e_s = 1; e_rdy = 1;
    end else begin
      emit_now = slot_strobe || (m_run != 0);
      cs = slot_strobe ? 0 : m_sub;
      cb = slot_strobe ? 0 : m_bit;
      rdy_old = !m_full;
      if (emit_now && cs == 0 && cb == 0) begin
        m_r384 = !ratio_256;
        m_n = 24 - 2 * int'(wl_sel);
        m_wl = m_full ? m_hl : '0;
        m_wr = m_full ? m_hr : '0;
        m_full = 0;
      end
      if (s_valid && rdy_old) begin
        m_hl = s_left; m_hr = s_right; m_full = 1; acc = 1;
      end
      if (emit_now) begin
        cpb = m_r384 ? 4 : 2;
        sb = m_r384 ? 24 : 32;
        first = (m_r384 && m_n != 24) ? 1 : 0;
        stop = first + m_n;
        if (cb >= first && cb < stop) begin
          e_l = m_wl[23 - (cb - first)];
          e_r = m_wr[23 - (cb - first)];
          e_b = (cs >= cpb / 2);
        end else begin
          e_l = 0; e_r = 0; e_b = 0;
        end
        e_w = (cb < sb / 2);
        e_s = !(cb >= stop);
        m_run = 1;
        cs++;
        if (cs == cpb) begin
          cs = 0; cb++;
          if (cb == sb) cb = 0;
        end
        m_sub = cs; m_bit = cb;
      end
      e_rdy = !m_full;
    end
  end

  task automatic chk(input logic act, input logic exp, input string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s [%s] t=%0t actual=%b expected=%b", what, phase, $time, act, exp);
    end
  endtask

  task automatic chk_int(input int act, input int exp, input string what);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s [%s] t=%0t actual=%0d expected=%0d", what, phase, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(ser_l, e_l, "R4 left line");
      chk(ser_r, e_r, "R4 right line");
      chk(bit_clk, e_b, "R3 bit clock");
      chk(word_clk, e_w, "R6 word clock");
      chk(settle_n, e_s, "R7 settle strobe");
      chk(s_ready, e_rdy, "R8 ready");
    end
  end

  // producer
  always @(negedge clk) begin
    if (feed_en) begin
      if (acc || !s_valid) begin
        seq++;
        if (seq % 5 == 0) begin
          s_left = 24'h800000; s_right = 24'h7FFFFF;
        end else begin
          s_left  = 24'((seq * 32'h9E3779B1) >> 3);
          s_right = 24'((seq * 32'h85EBCA6B) >> 5);
        end
      end
      s_valid = 1'b1;
    end else begin
      s_valid = 1'b0;
    end
  end

  task automatic idle_check(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(ser_l, 1'b0, "R1 left idle");
      chk(ser_r, 1'b0, "R1 right idle");
      chk(bit_clk, 1'b0, "R1 bit clock idle");
      chk(word_clk, 1'b0, "R1 word clock idle");
      chk(settle_n, 1'b1, "R1 settle idle");
      chk(s_ready, 1'b1, "R1 ready idle");
    end
  endtask

  task automatic pulse_strobe();
    @(negedge clk); slot_strobe = 1'b1;
    @(negedge clk); slot_strobe = 1'b0;
  endtask

  // waits for a slot start, then measures that slot
  task automatic measure(input int exp_len, input int exp_n, input int exp_first,
                         input int mid_wl, input bit want_zero);
    logic pw, pb;
    int cnt, rises, first, ones;
    pw = 1'b1;
    forever begin
      @(negedge clk);
      if (word_clk && !pw) break;
      pw = word_clk;
    end
    cnt = 0; rises = 0; first = -1; ones = 0; pb = bit_clk; pw = word_clk;
    forever begin
      @(negedge clk);
      cnt++;
      if (mid_wl >= 0 && cnt == 20) wl_sel = 2'(mid_wl);
      if (bit_clk && !pb) begin
        rises++;
        if (first < 0) first = cnt;
      end
      if (ser_l || ser_r) ones++;
      pb = bit_clk;
      if (word_clk && !pw) break;
      pw = word_clk;
    end
    chk_int(cnt, exp_len, "R2 slot length");
    chk_int(rises, exp_n, "R3 bit clock pulses");
    chk_int(first, exp_first, "R5 first bit clock rise");
    if (want_zero) chk_int(ones, 0, "R8 empty slot sends zeros");
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog expired [%s]", phase);
      report();
      $finish;
    end
  end

  initial begin
    phase = "R1 reset";
    idle_check(4);
    @(negedge clk); rst_n = 1'b1;
    phase = "R1 before strobe";
    idle_check(8);
    cmp_en = 1;
    feed_en = 1;

    phase = "R3 R5 256x";
    ratio_256 = 1'b1;
    pulse_strobe();
    for (int w = 0; w < 4; w++) begin
      wl_sel = 2'(w);
      measure(64, 24 - 2 * w, 1, -1, 0);
    end

    phase = "R3 R5 384x";
    ratio_256 = 1'b0;
    for (int w = 0; w < 4; w++) begin
      wl_sel = 2'(w);
      measure(96, 24 - 2 * w, (w == 0) ? 2 : 6, -1, 0);
    end

    phase = "R9 mid-slot change";
    wl_sel = 2'b11;
    measure(96, 18, 6, 0, 0);
    measure(96, 24, 2, -1, 0);
    wl_sel = 2'b10;
    repeat (30) @(negedge clk);
    ratio_256 = 1'b1;
    measure(64, 20, 1, -1, 0);

    phase = "R2 resync strobe";
    repeat (23) @(negedge clk);
    pulse_strobe();
    repeat (41) @(negedge clk);
    pulse_strobe();
    measure(64, 20, 1, -1, 0);

    phase = "R8 no samples";
    feed_en = 0;
    measure(64, 20, 1, -1, 0);
    measure(64, 20, 1, -1, 1);
    chk(s_ready, 1'b1, "R8 ready while empty");
    feed_en = 1;
    ratio_256 = 1'b0; wl_sel = 2'b01;
    measure(96, 22, 6, -1, 0);
    measure(96, 22, 6, -1, 0);

    phase = "R1 reset mid-run";
    feed_en = 0;
    @(negedge clk); rst_n = 1'b0;
    cmp_en = 0;
    idle_check(3);
    @(negedge clk); rst_n = 1'b1;
    idle_check(5);
    cmp_en = 1;
    feed_en = 1;
    phase = "R2 R4 after reset";
    ratio_256 = 1'b1; wl_sel = 2'b11;
    pulse_strobe();
    measure(64, 18, 1, -1, 0);
    measure(64, 18, 1, -1, 0);

    done = 1;
    report();
    $finish;
  end

endmodule